// File: doc/BRIEF.md
# Infrared Pulse Transmit Encoder

This block turns the NRZ bit stream leaving a UART transmit shift register into the return-to-zero pulse train that drives an infrared LED. A zero bit produces one short pulse placed in the middle of its bit period. A one bit leaves the line quiet. The pulse width is one of four fractions of a bit time. A polarity control lets the output drive either an active-high LED stage or a transceiver module that expects active-low pulses.

Bit timing comes from outside the block. The baud generator supplies an oversampling tick at 32 per bit, and the UART raises a one-cycle bit-start strobe at the first instant of every bit. That strobe sets the block's phase counter to zero and latches the data bit and the width code for the whole bit. Between bits, or whenever the transmit-active input is low, the line rests at the inactive level for the selected polarity. The intended rates are 2.4 to 115.2 kbit/s on a half-duplex link.

Top module: `irtx_pulse_encoder`

## Requirements
- R1: While rstN is low, irOut is 0 whatever the other inputs are.
- R2: A bit whose latched data value is 0, sent with txActive high, gives exactly one pulse on irOut.
- R3: A bit whose latched data value is 1 gives no pulse. irOut stays at its inactive level for the whole bit.
- R4: Let the phase be the number of ticks counted since bitStart. The pulse covers the following phases, centred on phase 16 of 32: widthSel 2'b00 gives 3/16 of a bit (phases 13..18), 2'b01 gives 1/16 (15..16), 2'b10 gives 1/32 (16..16), and 2'b11 gives 1/4 (12..19). irOut shows the phase state one clock after that state is reached.
- R5: widthSel is latched only in a cycle where bitStart is high. A change to widthSel in the middle of a bit does not alter that bit's pulse.
- R6: With invertPol at 0 the inactive level is 0 and a pulse drives 1. With invertPol at 1 the inactive level is 1 and a pulse drives 0. irOut follows invertPol one clock later.
- R7: With txActive low, irOut is at the inactive level one clock later and no pulse is produced.
- R8: The phase stops at 31. Extra ticks before the next bitStart produce no second pulse.
- R9: When bitStart and tickEn are high in the same cycle, bitStart wins and the phase becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | Oversampling tick, 32 per bit, one clock wide |
| bitStart | input | 1 | Start-of-bit strobe; clears the phase and latches txBit and widthSel |
| txBit | input | 1 | NRZ data bit from the transmit shift register |
| txActive | input | 1 | High while a transmission is in progress |
| widthSel | input | 2 | Pulse width code: 00=3/16, 01=1/16, 10=1/32, 11=1/4 of a bit |
| invertPol | input | 1 | 0: active-high pulse on an idle-low line; 1: active-low pulse on an idle-high line |
| irOut | output | 1 | Encoded infrared drive line |

## Verification
The main input pattern is random data bits with random width codes and a random gap between ticks. Random data separates the zero-bit and one-bit paths. Random width codes make every window edge appear at one-clock resolution. Random tick spacing shows that the pulse follows ticks and not raw clock cycles.

Directed patterns cover the remaining cases:
- runs with inverted polarity;
- a bit with txActive low;
- a width change in the middle of a bit;
- surplus ticks past phase 31;
- bitStart arriving together with a tick.

Each of these targets one mechanism: polarity, idle gating, latching at the bit boundary, phase saturation and strobe priority.

// File: rtl/irtx_pkg.sv
package irtx_pkg;

  // Strobes from control to the output datapath
  typedef struct packed {
    logic markNow;   // drive the active level on the next edge
    logic lineIdle;  // no transmission: hold the inactive level
  } irtx_strobe_t;

  // Pulse width in ticks for a width code (R4 encoding)
  function automatic int markTicks(input logic [1:0] sel, input int tpb);
    case (sel)
      2'b00:   return (tpb * 3) / 16;
      2'b01:   return tpb / 16;
      2'b10:   return tpb / 32;
      default: return tpb / 4;
    endcase
  endfunction

endpackage

// File: rtl/irtx_ctrl.sv
module irtx_ctrl
  import irtx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tickEn,
  input  logic         bitStart,
  input  logic         txBit,
  input  logic         txActive,
  input  logic [1:0]   widthSel,
  output irtx_strobe_t strb
);

  localparam int CNT_W  = $clog2(TICKS_PER_BIT);
  localparam int CENTER = TICKS_PER_BIT / 2;
  localparam int NCODES = 4;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_BIT - 1);

  logic [CNT_W-1:0] phase;
  logic             dataQ;
  logic [1:0]       widthQ;

  // Window bounds for each width code, centred on mid-bit
  logic [CNT_W-1:0] winLo [NCODES];
  logic [CNT_W-1:0] winHi [NCODES];

  for (genvar g = 0; g < NCODES; g++) begin : g_win
    localparam int W = markTicks(2'(g), TICKS_PER_BIT);
    assign winLo[g] = CNT_W'(CENTER - W / 2);
    assign winHi[g] = CNT_W'(CENTER - W / 2 + W - 1);
  end

  // Phase counter, bit latch and width latch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= LAST;
      dataQ  <= 1'b1;
      widthQ <= 2'b00;
    end else if (bitStart) begin
      phase  <= '0;
      dataQ  <= txBit;
      widthQ <= widthSel;
    end else if (tickEn && (phase != LAST)) begin
      phase <= phase + 1'b1;
    end
  end

  logic inWin;
  always_comb begin
    inWin         = (phase >= winLo[widthQ]) && (phase <= winHi[widthQ]);
    strb.lineIdle = !txActive;
    strb.markNow  = txActive && !dataQ && inWin;
  end

  // R9: bitStart has priority and clears the phase
  a_r9_start_clears: assert property (@(posedge clk) disable iff (!rstN)
    bitStart |=> (phase == '0));

  // R5: width code changes only at a bit boundary
  a_r5_width_held: assert property (@(posedge clk) disable iff (!rstN)
    !bitStart |=> $stable(widthQ));

  // R8: phase parks at the last tick
  a_r8_phase_parks: assert property (@(posedge clk) disable iff (!rstN)
    (phase == LAST) && !bitStart |=> (phase == LAST));

endmodule

// File: rtl/irtx_datapath.sv
module irtx_datapath
  import irtx_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  irtx_strobe_t strb,
  input  logic         invertPol,
  output logic         irOut
);

  logic armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irOut <= 1'b0;
      armed <= 1'b0;
    end else begin
      armed <= 1'b1;
      irOut <= (strb.markNow && !strb.lineIdle) ^ invertPol;
    end
  end

  // R7: idle request gives the inactive level on the next edge
  a_r7_idle_level: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(strb.lineIdle) |-> (irOut == $past(invertPol)));

  // R6: an active level only follows a mark request
  a_r6_active_needs_mark: assert property (@(posedge clk) disable iff (!rstN)
    armed && (irOut != $past(invertPol)) |-> $past(strb.markNow));

endmodule

// File: rtl/irtx_pulse_encoder.sv
module irtx_pulse_encoder
  import irtx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       bitStart,
  input  logic       txBit,
  input  logic       txActive,
  input  logic [1:0] widthSel,
  input  logic       invertPol,
  output logic       irOut
);

  irtx_strobe_t strb;

  irtx_ctrl #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tickEn   (tickEn),
    .bitStart (bitStart),
    .txBit    (txBit),
    .txActive (txActive),
    .widthSel (widthSel),
    .strb     (strb)
  );

  irtx_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .invertPol (invertPol),
    .irOut     (irOut)
  );

endmodule

// File: tb/irtx_pulse_encoder_test.sv
module irtx_pulse_encoder_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       bitStart = 1'b0;
  logic       txBit = 1'b1;
  logic       txActive = 1'b0;
  logic [1:0] widthSel = 2'b00;
  logic       invertPol = 1'b1;
  logic       irOut;

  irtx_pulse_encoder uut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .bitStart(bitStart),
    .txBit(txBit), .txActive(txActive), .widthSel(widthSel),
    .invertPol(invertPol), .irOut(irOut)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit cmpOn  = 1'b0;
  bit midFlag = 1'b0, overFlag = 1'b0, bothFlag = 1'b0;

  // Reference model state (from the requirements)
  int         mPhase = 31;
  logic       mBit = 1'b1;
  logic [1:0] mW = 2'b00;
  logic       expOut = 1'b0;
  string      expTag = "R1";

  function automatic int tWidth(input logic [1:0] s);
    case (s)
      2'b00:   return 6;
      2'b01:   return 2;
      2'b10:   return 1;
      default: return 8;
    endcase
  endfunction

  function automatic logic expMark(input int ph, input logic b,
                                   input logic [1:0] w, input logic act);
    int lo;
    lo = 16 - tWidth(w) / 2;
    return act && !b && (ph >= lo) && (ph <= lo + tWidth(w) - 1);
  endfunction

  task automatic check(input bit ok, input string tag, input logic act, input logic exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rstN) begin
      mPhase = 31; mBit = 1'b1; mW = 2'b00; expOut = 1'b0; expTag = "R1";
    end else begin
      logic mk;
      mk = expMark(mPhase, mBit, mW, txActive);
      expOut = mk ^ invertPol;
      if (midFlag)        expTag = "R5";
      else if (overFlag)  expTag = "R8";
      else if (bothFlag)  expTag = "R9";
      else if (!txActive) expTag = "R7";
      else if (invertPol) expTag = "R6";
      else if (mk)        expTag = "R4";
      else if (mBit)      expTag = "R3";
      else                expTag = "R2";
      if (bitStart) begin
        mPhase = 0; mBit = txBit; mW = widthSel;
      end else if (tickEn && mPhase < 31) begin
        mPhase++;
      end
    end
  end

  always @(negedge clk)
    if (cmpOn) check(irOut === expOut, expTag, irOut, expOut);

  // Per-bit pulse counting
  int   pulses;
  logic prevAct;
  logic curInv;

  task automatic stepClk();
    logic a;
    @(negedge clk);
    a = (irOut !== curInv);
    if (a && !prevAct) pulses++;
    prevAct = a;
  endtask

  task automatic sendBit(input logic b, input logic [1:0] w, input logic inv,
                         input logic act, input int gap, input bit midChg,
                         input int nTicks, input bit together);
    txBit = b; widthSel = w; invertPol = inv; txActive = act; curInv = inv;
    bitStart = 1'b1;
    if (together) begin tickEn = 1'b1; bothFlag = 1'b1; end
    pulses = 0; prevAct = 1'b0;
    stepClk();
    bitStart = 1'b0; tickEn = 1'b0;
    for (int t = 0; t < nTicks; t++) begin
      repeat (gap) stepClk();
      if (midChg && t == 8) begin widthSel = ~w; midFlag = 1'b1; end
      if (t >= 31) overFlag = 1'b1;
      tickEn = 1'b1;
      stepClk();
      tickEn = 1'b0;
    end
    stepClk();
    stepClk();
    // R2 / R3 / R7: pulse count per bit
    if (!act)
      check(pulses == 0, "R7", 1'(pulses), 1'b0);
    else if (b)
      check(pulses == 0, "R3", 1'(pulses), 1'b0);
    else
      check(pulses == 1, "R2", 1'(pulses), 1'b1);
    midFlag = 1'b0; overFlag = 1'b0; bothFlag = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h1EC0DE));
    curInv = 1'b1;
    repeat (2) @(negedge clk);
    cmpOn = 1'b1;               // R1: reset level checked with invertPol high
    repeat (4) @(negedge clk);
    invertPol = 1'b0; curInv = 1'b0;
    rstN = 1'b1;
    txActive = 1'b1;
    repeat (3) @(negedge clk);

    // R4: each width code directed, normal polarity
    for (int w = 0; w < 4; w++) sendBit(1'b0, 2'(w), 1'b0, 1'b1, 1, 1'b0, 31, 1'b0);
    sendBit(1'b1, 2'b11, 1'b0, 1'b1, 1, 1'b0, 31, 1'b0);              // R3
    // R6: inverted polarity
    for (int w = 0; w < 4; w++) sendBit(1'b0, 2'(w), 1'b1, 1'b1, 0, 1'b0, 31, 1'b0);
    sendBit(1'b1, 2'b00, 1'b1, 1'b1, 0, 1'b0, 31, 1'b0);
    sendBit(1'b0, 2'b00, 1'b0, 1'b0, 1, 1'b0, 31, 1'b0);              // R7
    sendBit(1'b0, 2'b00, 1'b1, 1'b0, 1, 1'b0, 31, 1'b0);              // R7 inverted
    sendBit(1'b0, 2'b10, 1'b0, 1'b1, 1, 1'b1, 31, 1'b0);              // R5
    sendBit(1'b0, 2'b11, 1'b0, 1'b1, 0, 1'b0, 45, 1'b0);              // R8
    sendBit(1'b0, 2'b01, 1'b0, 1'b1, 2, 1'b0, 31, 1'b1);              // R9

    // Random bits
    for (int i = 0; i < 200; i++) begin
      logic b, inv, act;
      logic [1:0] w;
      b   = 1'($urandom_range(0, 1));
      w   = 2'($urandom_range(0, 3));
      inv = ($urandom_range(0, 4) == 0);
      act = ($urandom_range(0, 9) != 0);
      sendBit(b, w, inv, act, $urandom_range(0, 2), ($urandom_range(0, 7) == 0),
              ($urandom_range(0, 9) == 0) ? 36 : 31, 1'b0);
    end

    cmpOn = 1'b0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(posedge clk)
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end

endmodule